// File: doc/BRIEF.md
# Timer Compare Interrupt Prioritizer

This block gathers compare-match events from six timers. Every timer has two match sources, A and B, which gives twelve sources. Each source has a sticky cause flag and an enable bit. Each timer has one 3-bit priority level, and both of its sources use that level. Software reaches the flags, enables and levels through a small register port. Reads are combinational. A write of ones to the flag register clears the flags at those bit positions.

On every clock, the block looks at the enabled pending sources and picks one winner. The highest level wins. If levels are equal, the lower timer number wins, and inside one timer source B wins over source A. The block registers the winner's level, source index and DMA channel number. It also forms an accept signal from the registered winner and the CPU's interrupt-enable bit and current interrupt level.

Top module: `tmr_cmp_irq_prio`

## Requirements
- R1: A compare match sets the cause flag of its source on the next clock edge, whatever the state of the enable bit. The flag stays set until it is cleared. In the flag and enable registers, bit 2t is source B of timer t and bit 2t+1 is source A of timer t.
- R2: Writing address 0 clears every flag whose data bit is 1. If a match for a source arrives in the same cycle as its clear, that flag stays set.
- R3: A source is a request only when both its cause flag and its enable bit are 1. Flags that are set but not enabled never make the output valid.
- R4: Each timer t has a 3-bit level at bits [3t+2:3t] of address 2. Both sources of the timer use this level.
- R5: Among the requests, the one with the highest level wins.
- R6: If two requests have the same level, the one from the lower timer number wins.
- R7: Inside one timer, source B wins over source A when both are requests.
- R8: The source index output is 2t for source B of timer t and 2t+1 for source A of timer t. The DMA channel output is 7 plus that index, so it runs from 0x07 (timer 0 B) to 0x12 (timer 5 A).
- R9: The accept output is 1 only when the winner is valid, the CPU enable input is 1, and the CPU level is strictly below the winner's level. A winner at level 0 is therefore never accepted.
- R10: The winner outputs are registered and change one clock after the flags change. After reset, all flags, enables, levels and winner outputs are 0.
- R11: Address 1 holds the enables and address 2 holds the levels. Both read back exactly what was written. Unused bits and address 3 read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| match_a | input | 6 | Compare-match A pulse, one bit per timer |
| match_b | input | 6 | Compare-match B pulse, one bit per timer |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register write address |
| wr_data | input | 32 | Register write data |
| rd_addr | input | 2 | Register read address |
| rd_data | output | 32 | Register read data (combinational) |
| cpu_ie | input | 1 | CPU interrupt enable |
| cpu_il | input | 3 | CPU current interrupt level |
| irq_valid | output | 1 | A winning request exists |
| irq_level | output | 3 | Level of the winner |
| irq_src | output | 4 | Source index of the winner |
| irq_dma_ch | output | 5 | DMA channel number of the winner |
| irq_accept | output | 1 | The CPU would take the winner now |

## Verification
The hardest case to reach from the ports is a flag clear that arrives in the same cycle as a new match for the same source. The bench drives the write strobe and the match pulse on the same falling edge, so the register edge sees both together. It then reads the flags back. Tie-breaks are reached with table vectors that clear all flags, program the levels, and then pulse several matches together, so the winner is decided by the ordering rules alone.

// File: rtl/tmr_irq_pkg.sv
package tmr_irq_pkg;
  typedef enum logic [1:0] {
    RA_FLAGS  = 2'd0,
    RA_ENABLE = 2'd1,
    RA_LEVEL  = 2'd2,
    RA_NONE   = 2'd3
  } reg_addr_e;
endpackage

// File: rtl/tmr_cause_bank.sv
module tmr_cause_bank #(
  parameter int NSRC = 12
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] set_vec,
  input  logic            clr_en,
  input  logic [NSRC-1:0] clr_vec,
  output logic [NSRC-1:0] flags
);
  logic [NSRC-1:0] flags_d;
  logic            flags_ce;

  always_comb begin
    flags_ce = clr_en || (|set_vec);
    flags_d  = flags;
    if (clr_en) flags_d = flags_d & ~clr_vec;
    flags_d = flags_d | set_vec;   // a new match beats a clear
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        flags <= '0;
    else if (flags_ce) flags <= flags_d;
  end
endmodule

// File: rtl/tmr_cfg_regs.sv
module tmr_cfg_regs #(
  parameter int NSRC  = 12,
  parameter int N_TMR = 6,
  parameter int LVL_W = 3,
  parameter int DW    = 32
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   en_we,
  input  logic                   lvl_we,
  input  logic [DW-1:0]          wdata,
  output logic [NSRC-1:0]        enables,
  output logic [N_TMR*LVL_W-1:0] levels
);
  localparam int LVW = N_TMR * LVL_W;

  logic [NSRC-1:0] en_d;
  logic [LVW-1:0]  lvl_d;

  always_comb begin
    en_d  = wdata[NSRC-1:0];
    lvl_d = wdata[LVW-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     enables <= '0;
    else if (en_we) enables <= en_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      levels <= '0;
    else if (lvl_we) levels <= lvl_d;
  end
endmodule

// File: rtl/tmr_prio_pick.sv
module tmr_prio_pick #(
  parameter int NSRC     = 12,
  parameter int N_TMR    = 6,
  parameter int LVL_W    = 3,
  parameter int SRC_W    = 4,
  parameter int DMA_W    = 5,
  parameter int DMA_BASE = 7
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [NSRC-1:0]        pend,
  input  logic [N_TMR*LVL_W-1:0] levels,
  output logic                   win_v,
  output logic [LVL_W-1:0]       win_lvl,
  output logic [SRC_W-1:0]       win_src,
  output logic [DMA_W-1:0]       win_dma
);
  logic [LVL_W-1:0] src_lvl [NSRC];

  // source 2t = timer t B, 2t+1 = timer t A: both take the timer's level
  for (genvar s = 0; s < NSRC; s++) begin : g_lvl
    assign src_lvl[s] = levels[(s/2)*LVL_W +: LVL_W];
  end

  logic             best_v;
  logic [LVL_W-1:0] best_l;
  logic [SRC_W-1:0] best_s;
  logic [DMA_W-1:0] best_d;

  always_comb begin
    best_v = 1'b0;
    best_l = '0;
    best_s = '0;
    // walk downwards with >= so the lowest index wins among equal levels
    for (int s = NSRC - 1; s >= 0; s--) begin
      if (pend[s] && (!best_v || src_lvl[s] >= best_l)) begin
        best_v = 1'b1;
        best_l = src_lvl[s];
        best_s = SRC_W'(s);
      end
    end
    best_d = DMA_W'(DMA_BASE) + DMA_W'(best_s);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      win_v   <= 1'b0;
      win_lvl <= '0;
      win_src <= '0;
      win_dma <= '0;
    end else begin
      win_v   <= best_v;
      win_lvl <= best_l;
      win_src <= best_s;
      win_dma <= best_v ? best_d : '0;
    end
  end
endmodule

// File: rtl/tmr_cmp_irq_prio.sv
module tmr_cmp_irq_prio
  import tmr_irq_pkg::*;
#(
  parameter int N_TMR    = 6,
  parameter int LVL_W    = 3,
  parameter int DW       = 32,
  parameter int DMA_BASE = 7,
  parameter int DMA_W    = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_TMR-1:0] match_a,
  input  logic [N_TMR-1:0] match_b,
  input  logic             wr_en,
  input  logic [1:0]       wr_addr,
  input  logic [DW-1:0]    wr_data,
  input  logic [1:0]       rd_addr,
  output logic [DW-1:0]    rd_data,
  input  logic             cpu_ie,
  input  logic [LVL_W-1:0] cpu_il,
  output logic             irq_valid,
  output logic [LVL_W-1:0] irq_level,
  output logic [3:0]       irq_src,
  output logic [DMA_W-1:0] irq_dma_ch,
  output logic             irq_accept
);
  localparam int NSRC  = 2 * N_TMR;
  localparam int SRC_W = $clog2(NSRC);
  localparam int LVW   = N_TMR * LVL_W;

  logic [NSRC-1:0]  set_vec;
  logic [NSRC-1:0]  cause_q;
  logic [NSRC-1:0]  enable_q;
  logic [LVW-1:0]   level_q;
  logic [NSRC-1:0]  pend;
  logic [SRC_W-1:0] win_src;

  for (genvar t = 0; t < N_TMR; t++) begin : g_map
    assign set_vec[2*t]   = match_b[t];
    assign set_vec[2*t+1] = match_a[t];
  end

  tmr_cause_bank #(.NSRC(NSRC)) u_cause (
    .clk     (clk),
    .rst_n   (rst_n),
    .set_vec (set_vec),
    .clr_en  (wr_en && (wr_addr == RA_FLAGS)),
    .clr_vec (wr_data[NSRC-1:0]),
    .flags   (cause_q)
  );

  tmr_cfg_regs #(.NSRC(NSRC), .N_TMR(N_TMR), .LVL_W(LVL_W), .DW(DW)) u_cfg (
    .clk     (clk),
    .rst_n   (rst_n),
    .en_we   (wr_en && (wr_addr == RA_ENABLE)),
    .lvl_we  (wr_en && (wr_addr == RA_LEVEL)),
    .wdata   (wr_data),
    .enables (enable_q),
    .levels  (level_q)
  );

  assign pend = cause_q & enable_q;

  tmr_prio_pick #(
    .NSRC(NSRC), .N_TMR(N_TMR), .LVL_W(LVL_W),
    .SRC_W(SRC_W), .DMA_W(DMA_W), .DMA_BASE(DMA_BASE)
  ) u_pick (
    .clk     (clk),
    .rst_n   (rst_n),
    .pend    (pend),
    .levels  (level_q),
    .win_v   (irq_valid),
    .win_lvl (irq_level),
    .win_src (win_src),
    .win_dma (irq_dma_ch)
  );

  assign irq_src    = 4'(win_src);
  assign irq_accept = irq_valid && cpu_ie && (cpu_il < irq_level);

  always_comb begin
    rd_data = '0;
    case (rd_addr)
      RA_FLAGS:  rd_data[NSRC-1:0] = cause_q;
      RA_ENABLE: rd_data[NSRC-1:0] = enable_q;
      RA_LEVEL:  rd_data[LVW-1:0]  = level_q;
      default:   rd_data = '0;
    endcase
  end
endmodule

// File: rtl/tmr_cmp_irq_prio_chk.sv
module tmr_cmp_irq_prio_chk #(
  parameter int NSRC  = 12,
  parameter int LVL_W = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic [NSRC-1:0]  set_vec,
  input logic [NSRC-1:0]  cause_q,
  input logic [NSRC-1:0]  enable_q,
  input logic             wr_en,
  input logic [1:0]       wr_addr,
  input logic [31:0]      wr_data,
  input logic             cpu_ie,
  input logic [LVL_W-1:0] cpu_il,
  input logic             irq_valid,
  input logic [LVL_W-1:0] irq_level,
  input logic [3:0]       irq_src,
  input logic             irq_accept
);
  logic [NSRC-1:0] pend_d;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend_d <= '0;
    else        pend_d <= cause_q & enable_q;
  end

  AST_MATCH_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    (|set_vec) |=> ((cause_q & $past(set_vec)) == $past(set_vec)));   // R1
  AST_CLEAR_WINS_ALONE: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == 2'd0 && set_vec == '0) |=>
      ((cause_q & $past(wr_data[NSRC-1:0])) == '0));                  // R2
  AST_WIN_IS_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
    irq_valid |-> pend_d[irq_src]);                                   // R3
  AST_NO_PEND_NO_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_d == '0) |-> !irq_valid);                                   // R10
  AST_ACCEPT_NEEDS_IE: assert property (@(posedge clk) disable iff (!rst_n)
    !cpu_ie |-> !irq_accept);                                         // R9
  AST_ACCEPT_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
    irq_accept |-> (irq_valid && irq_level > cpu_il));                // R9
endmodule

bind tmr_cmp_irq_prio tmr_cmp_irq_prio_chk #(.NSRC(NSRC), .LVL_W(LVL_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .set_vec(set_vec), .cause_q(cause_q),
  .enable_q(enable_q), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
  .cpu_ie(cpu_ie), .cpu_il(cpu_il), .irq_valid(irq_valid),
  .irq_level(irq_level), .irq_src(irq_src), .irq_accept(irq_accept)
);

// File: tb/tmr_cmp_irq_prio_test.sv
module tmr_cmp_irq_prio_test;
  logic        clk;
  logic        rst_n;
  logic [5:0]  match_a, match_b;
  logic        wr_en;
  logic [1:0]  wr_addr, rd_addr;
  logic [31:0] wr_data, rd_data;
  logic        cpu_ie;
  logic [2:0]  cpu_il;
  logic        irq_valid, irq_accept;
  logic [2:0]  irq_level;
  logic [3:0]  irq_src;
  logic [4:0]  irq_dma_ch;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  tmr_cmp_irq_prio uut (
    .clk(clk), .rst_n(rst_n), .match_a(match_a), .match_b(match_b),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .cpu_ie(cpu_ie), .cpu_il(cpu_il),
    .irq_valid(irq_valid), .irq_level(irq_level), .irq_src(irq_src),
    .irq_dma_ch(irq_dma_ch), .irq_accept(irq_accept)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  typedef struct packed {
    logic [11:0] set;
    logic [11:0] en;
    logic [17:0] lvl;
    logic        ie;
    logic [2:0]  il;
    logic        e_v;
    logic [3:0]  e_src;
    logic [2:0]  e_lvl;
    logic        e_acc;
    logic [7:0]  req;
  } vec_t;

  localparam int NV = 10;
  localparam vec_t VEC [NV] = '{
    '{12'h008, 12'hFFF, {6{3'd5}}, 1'b1, 3'd2, 1'b1, 4'd3,  3'd5, 1'b1, 8'd5},
    '{12'h00C, 12'hFFF, {6{3'd5}}, 1'b1, 3'd2, 1'b1, 4'd2,  3'd5, 1'b1, 8'd7},
    '{12'h012, 12'hFFF, {6{3'd4}}, 1'b1, 3'd0, 1'b1, 4'd1,  3'd4, 1'b1, 8'd6},
    '{12'h012, 12'hFFF, {3'd0,3'd0,3'd0,3'd6,3'd0,3'd4}, 1'b1, 3'd5, 1'b1, 4'd4, 3'd6, 1'b1, 8'd5},
    '{12'h801, 12'hFFE, {6{3'd3}}, 1'b1, 3'd0, 1'b1, 4'd11, 3'd3, 1'b1, 8'd3},
    '{12'h001, 12'hFFE, {6{3'd3}}, 1'b1, 3'd0, 1'b0, 4'd0,  3'd0, 1'b0, 8'd3},
    '{12'h040, 12'hFFF, {6{3'd7}}, 1'b0, 3'd0, 1'b1, 4'd6,  3'd7, 1'b0, 8'd9},
    '{12'h100, 12'hFFF, {6{3'd4}}, 1'b1, 3'd4, 1'b1, 4'd8,  3'd4, 1'b0, 8'd9},
    '{12'h200, 12'hFFF, {6{3'd0}}, 1'b1, 3'd0, 1'b1, 4'd9,  3'd0, 1'b0, 8'd9},
    '{12'h800, 12'hFFF, {6{3'd2}}, 1'b1, 3'd1, 1'b1, 4'd11, 3'd2, 1'b1, 8'd8}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0; wr_data = '0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    rd_addr = a;
    #1 d = rd_data;
  endtask

  task automatic drive_set(input logic [11:0] v);
    for (int t = 0; t < 6; t++) begin
      match_b[t] = v[2*t];
      match_a[t] = v[2*t+1];
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    rst_n = 1'b0; match_a = '0; match_b = '0; wr_en = 1'b0; wr_addr = '0;
    wr_data = '0; rd_addr = '0; cpu_ie = 1'b0; cpu_il = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R10: reset state
    chk("R10 valid after reset", 32'(irq_valid), 0);
    chk("R10 dma after reset", 32'(irq_dma_ch), 0);
    rd(2'd0, d); chk("R10 flags after reset", d, 0);
    rd(2'd2, d); chk("R10 levels after reset", d, 0);

    // R1: disabled match still latches; stays sticky
    drive_set(12'h020);
    @(negedge clk);
    drive_set(12'h000);
    rd(2'd0, d); chk("R1 flag set while disabled", d, 32'h020);
    @(negedge clk);
    rd(2'd0, d); chk("R1 flag sticky", d, 32'h020);
    chk("R3 disabled flag no request", 32'(irq_valid), 0);

    // R11: register readback
    wr(2'd1, 32'hFFFF_FA5C);
    rd(2'd1, d); chk("R11 enable readback", d, 32'hA5C);
    wr(2'd2, 32'hFFFF_FFFF);
    rd(2'd2, d); chk("R11 level readback", d, 32'h3FFFF);
    rd(2'd3, d); chk("R11 unused address", d, 0);

    // R2: clear with simultaneous match on bit 5, plain clear on bit 4
    drive_set(12'h010);
    @(negedge clk);
    drive_set(12'h020);
    wr_en = 1'b1; wr_addr = 2'd0; wr_data = 32'h030;
    @(negedge clk);
    wr_en = 1'b0; wr_data = '0; drive_set(12'h000);
    rd(2'd0, d); chk("R2 match beats clear", d, 32'h020);
    wr(2'd0, 32'hFFF);
    rd(2'd0, d); chk("R2 write one clears", d, 0);

    // R10: timing, output one clock after the flag
    wr(2'd1, 32'hFFF);
    wr(2'd2, 32'h0);
    drive_set(12'h001);
    @(negedge clk);
    drive_set(12'h000);
    chk("R10 not yet valid when flag just set", 32'(irq_valid), 0);
    @(negedge clk);
    chk("R10 valid one clock later", 32'(irq_valid), 1);

    // table walk
    for (int i = 0; i < NV; i++) begin
      string tag;
      tag = $sformatf("R%0d vec%0d", VEC[i].req, i);
      wr(2'd0, 32'hFFF);
      wr(2'd1, 32'(VEC[i].en));
      wr(2'd2, 32'(VEC[i].lvl));
      cpu_ie = VEC[i].ie; cpu_il = VEC[i].il;
      drive_set(VEC[i].set);
      @(negedge clk);
      drive_set(12'h000);
      @(negedge clk);
      chk({tag, " valid"}, 32'(irq_valid), 32'(VEC[i].e_v));
      if (VEC[i].e_v) begin
        chk({tag, " src"}, 32'(irq_src), 32'(VEC[i].e_src));
        chk({tag, " level"}, 32'(irq_level), 32'(VEC[i].e_lvl));
        chk({tag, " R8 dma"}, 32'(irq_dma_ch), 32'(VEC[i].e_src) + 7);
      end
      chk({tag, " R9 accept"}, 32'(irq_accept), 32'(VEC[i].e_acc));
    end
    // vec0/1: R7 B over A; vec2: R6 lower timer; vec3: R5 highest level;
    // vec4/5: R3 enable gating; vec6-8: R9 accept rules; vec9: R8 top channel
    // R4: level of timer 4 applies to both its sources
    wr(2'd0, 32'hFFF);
    wr(2'd2, 32'({3'd0, 3'd6, 3'd0, 3'd0, 3'd0, 3'd0}));
    drive_set(12'h200);
    @(negedge clk);
    drive_set(12'h000);
    @(negedge clk);
    chk("R4 source A uses timer level", 32'(irq_level), 6);

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule